// File: doc/BRIEF.md
# Pseudo-Random Fault-Coverage Test Controller

This block runs a fault-simulation campaign over an external simulation network. After a start pulse it latches a feedback polynomial, a seed, the number of collapsed faults, a coverage target in whole percent and a vector budget. It then marks every fault below that count as pending. For each pattern it pulses a network re-initialise strobe and then checks coverage. If the run is to go on, it presents the current shift-register state as the test vector and waits for a completion strobe. With that strobe comes a mask of the faults the vector exposed, including faults on primary input lines.

Exposed faults are crossed off the pending store and added to a running detected count. Every vector that exposes at least one fault not seen before is written into a small capture queue. The run ends when the target coverage is met or the random supply runs out. The supply runs out when the generator returns to its seed or the vector budget is used up. The block then reports the faults still pending by scanning every fault index in ascending order and flagging the ones still set. A one-cycle completion pulse follows the scan. The final detected count stays on its output for the coverage figure.

Top module: `rand_cov_ctrl`

## Requirements
- R1: After reset the block is idle: busy, netInit, vecValid, scanValid, capValid and done are low and detCount is 0.
- R2: A start pulse while idle latches all configuration, sets the pending bit of every fault index below faultTotal, clears every other pending bit, zeroes detCount and empties the capture queue. A start pulse while busy has no effect.
- R3: The first vector of a run equals the seed. Each later vector is the previous one shifted left by one, with bit 0 filled by the XOR of the bits selected by the polynomial: next = {v[W-2:0], ^(v & poly)}.
- R4: Each vector cycle pulses netInit for one clock. The coverage decision follows one clock later. If the run continues, vecValid pulses for one clock in the clock after that, and the block then waits for simDone.
- R5: When simDone is high in the wait phase, every pending fault whose detectMask bit is set is cleared, and detCount grows by the number of faults cleared. Mask bits of faults already cleared, or at or above faultTotal, change nothing.
- R6: Coverage is met when detCount*100 >= targetPct*faultTotal. It is evaluated after every netInit, and when it is met no further vector is applied.
- R7: The supply is exhausted when the generator state after a completed vector equals the seed, or when the number of completed vectors has reached maxVectors. An exhausted run applies no further vector.
- R8: Every vector that clears at least one fault is pushed into a CAP_DEPTH-entry first-in-first-out queue. capValid is high while the queue holds an entry, capVec shows the oldest one, and capPop removes it. A push into a full queue is dropped.
- R9: After the run stops, the block spends FAULTS clocks scanning indices 0 upward. scanIdx carries the index, and scanValid is high exactly for the indices still pending. done then pulses for one clock and the block returns to idle.
- R10: testVec does not change while the block waits for simDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| poly | input | VEC_W | Feedback tap mask of the pattern generator |
| seed | input | VEC_W | Initial generator state |
| faultTotal | input | CNT_W | Number of collapsed faults, at most FAULTS |
| targetPct | input | 7 | Coverage target in whole percent |
| maxVectors | input | VCNT_W | Vector budget |
| simDone | input | 1 | Simulation of the applied vector finished |
| detectMask | input | FAULTS | Faults exposed by the applied vector |
| capPop | input | 1 | Removes the oldest capture queue entry |
| netInit | output | 1 | Re-initialise pulse to the simulation network |
| vecValid | output | 1 | Apply pulse for testVec |
| testVec | output | VEC_W | Current test vector |
| busy | output | 1 | A run is in progress |
| capValid | output | 1 | Capture queue not empty |
| capVec | output | VEC_W | Oldest captured vector |
| scanValid | output | 1 | scanIdx names an undetected fault |
| scanIdx | output | IDX_W | Fault index under scan |
| done | output | 1 | End-of-run pulse |
| detCount | output | CNT_W | Number of faults detected so far |

## Verification
A corrupted pending bit shows up in two places. It changes detCount at the first later vector whose mask touches that fault, and it also surfaces as a missing or extra scan index in the final report. A wrong generator step is visible on the very next vecValid, since testVec is compared with an independently stepped model on every apply. A faulty stop decision surfaces at once as an extra vector or an early done. A defect in the queue appears on the next capPop as a wrong or missing vector.

// File: rtl/rand_cov_pkg.sv
package rand_cov_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_CHECK, ST_APPLY, ST_WAIT, ST_SCAN, ST_DONE
  } ctrlState_t;

  typedef struct packed {
    logic load;      // latch configuration, arm pending store
    logic capture;   // accept detections, advance generator
    logic scanStep;  // move scan pointer
  } dpCmd_t;
endpackage

// File: rtl/rand_cov_dp.sv
module rand_cov_dp
  import rand_cov_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int FAULTS    = 64,
  parameter int CAP_DEPTH = 4,
  parameter int VCNT_W    = 16,
  localparam int CNT_W    = $clog2(FAULTS + 1),
  localparam int IDX_W    = $clog2(FAULTS),
  localparam int PTR_W    = $clog2(CAP_DEPTH),
  localparam int PROD_W   = CNT_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [VEC_W-1:0]  poly,
  input  logic [VEC_W-1:0]  seed,
  input  logic [CNT_W-1:0]  faultTotal,
  input  logic [6:0]        targetPct,
  input  logic [VCNT_W-1:0] maxVectors,
  input  logic [FAULTS-1:0] detectMask,
  input  logic              capPop,
  output logic [VEC_W-1:0]  testVec,
  output logic              covMet,
  output logic              exhausted,
  output logic              scanLast,
  output logic              scanHit,
  output logic [IDX_W-1:0]  scanIdx,
  output logic              capValid,
  output logic [VEC_W-1:0]  capVec,
  output logic [CNT_W-1:0]  detCount
);
  logic [VEC_W-1:0]  lfsr, lfsrNext, seedReg, polyReg;
  logic [CNT_W-1:0]  totalReg;
  logic [6:0]        targetReg;
  logic [VCNT_W-1:0] maxReg, vecCount;
  logic              wrapped;
  logic [FAULTS-1:0] pending, newHits;
  logic [CNT_W-1:0]  hitCount;
  logic [IDX_W-1:0]  scanPtr;
  logic [VEC_W-1:0]  capMem [CAP_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W:0]    capCount;
  logic              pushEn, popEn;

  function automatic logic [CNT_W-1:0] countHits(input logic [FAULTS-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < FAULTS; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  assign lfsrNext  = {lfsr[VEC_W-2:0], ^(lfsr & polyReg)};
  assign newHits   = pending & detectMask;
  assign hitCount  = countHits(newHits);
  assign covMet    = (PROD_W'(detCount) * PROD_W'(100)) >= (PROD_W'(targetReg) * PROD_W'(totalReg));
  assign exhausted = wrapped || (vecCount >= maxReg);
  assign scanLast  = (scanPtr == IDX_W'(FAULTS - 1));
  assign scanHit   = pending[scanPtr];
  assign scanIdx   = scanPtr;
  assign testVec   = lfsr;
  assign pushEn    = cmd.capture && (hitCount != '0) && (capCount != (PTR_W+1)'(CAP_DEPTH));
  assign popEn     = capPop && (capCount != '0);
  assign capValid  = (capCount != '0);
  assign capVec    = capMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= '0; seedReg <= '0; polyReg <= '0; totalReg <= '0; targetReg <= '0;
      maxReg <= '0; vecCount <= '0; wrapped <= 1'b0; pending <= '0; detCount <= '0;
      scanPtr <= '0;
    end else if (cmd.load) begin
      lfsr <= seed; seedReg <= seed; polyReg <= poly; totalReg <= faultTotal;
      targetReg <= targetPct; maxReg <= maxVectors; vecCount <= '0; wrapped <= 1'b0;
      detCount <= '0; scanPtr <= '0;
      for (int i = 0; i < FAULTS; i++) pending[i] <= (i < int'(faultTotal));
    end else begin
      if (cmd.capture) begin
        pending  <= pending & ~detectMask;
        detCount <= detCount + hitCount;
        lfsr     <= lfsrNext;
        wrapped  <= (lfsrNext == seedReg);
        vecCount <= vecCount + 1'b1;
      end
      if (cmd.scanStep) scanPtr <= scanLast ? '0 : scanPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; capCount <= '0;
      for (int i = 0; i < CAP_DEPTH; i++) capMem[i] <= '0;
    end else if (cmd.load) begin
      wrPtr <= '0; rdPtr <= '0; capCount <= '0;
    end else begin
      if (pushEn) begin
        capMem[wrPtr] <= lfsr;
        wrPtr <= wrPtr + 1'b1;
      end
      if (popEn) rdPtr <= rdPtr + 1'b1;
      capCount <= capCount + (PTR_W+1)'(pushEn) - (PTR_W+1)'(popEn);
    end
  end
endmodule

// File: rtl/rand_cov_fsm.sv
module rand_cov_fsm
  import rand_cov_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   simDone,
  input  logic   covMet,
  input  logic   exhausted,
  input  logic   scanLast,
  input  logic   scanHit,
  output dpCmd_t cmd,
  output logic   netInit,
  output logic   vecValid,
  output logic   scanValid,
  output logic   done,
  output logic   busy
);
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_INIT;
      ST_INIT:  stateNext = ST_CHECK;
      ST_CHECK: stateNext = (covMet || exhausted) ? ST_SCAN : ST_APPLY;
      ST_APPLY: stateNext = ST_WAIT;
      ST_WAIT:  if (simDone) stateNext = ST_INIT;
      ST_SCAN:  if (scanLast) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmd.load     = (state == ST_IDLE) && start;
  assign cmd.capture  = (state == ST_WAIT) && simDone;
  assign cmd.scanStep = (state == ST_SCAN);
  assign netInit      = (state == ST_INIT);
  assign vecValid     = (state == ST_APPLY);
  assign scanValid    = (state == ST_SCAN) && scanHit;
  assign done         = (state == ST_DONE);
  assign busy         = (state != ST_IDLE);
endmodule

// File: rtl/rand_cov_ctrl.sv
module rand_cov_ctrl
  import rand_cov_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int FAULTS    = 64,
  parameter int CAP_DEPTH = 4,
  parameter int VCNT_W    = 16,
  localparam int CNT_W    = $clog2(FAULTS + 1),
  localparam int IDX_W    = $clog2(FAULTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VEC_W-1:0]  poly,
  input  logic [VEC_W-1:0]  seed,
  input  logic [CNT_W-1:0]  faultTotal,
  input  logic [6:0]        targetPct,
  input  logic [VCNT_W-1:0] maxVectors,
  input  logic              simDone,
  input  logic [FAULTS-1:0] detectMask,
  input  logic              capPop,
  output logic              netInit,
  output logic              vecValid,
  output logic [VEC_W-1:0]  testVec,
  output logic              busy,
  output logic              capValid,
  output logic [VEC_W-1:0]  capVec,
  output logic              scanValid,
  output logic [IDX_W-1:0]  scanIdx,
  output logic              done,
  output logic [CNT_W-1:0]  detCount
);
  dpCmd_t cmd;
  logic covMet, exhausted, scanLast, scanHit;

  rand_cov_fsm fsm (
    .clk(clk), .rstN(rstN), .start(start), .simDone(simDone),
    .covMet(covMet), .exhausted(exhausted), .scanLast(scanLast), .scanHit(scanHit),
    .cmd(cmd), .netInit(netInit), .vecValid(vecValid), .scanValid(scanValid),
    .done(done), .busy(busy)
  );

  rand_cov_dp #(.VEC_W(VEC_W), .FAULTS(FAULTS), .CAP_DEPTH(CAP_DEPTH), .VCNT_W(VCNT_W)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .poly(poly), .seed(seed),
    .faultTotal(faultTotal), .targetPct(targetPct), .maxVectors(maxVectors),
    .detectMask(detectMask), .capPop(capPop), .testVec(testVec), .covMet(covMet),
    .exhausted(exhausted), .scanLast(scanLast), .scanHit(scanHit), .scanIdx(scanIdx),
    .capValid(capValid), .capVec(capVec), .detCount(detCount)
  );
endmodule

// File: rtl/rand_cov_ctrl_chk.sv
module rand_cov_ctrl_chk #(
  parameter int VEC_W  = 16,
  parameter int FAULTS = 64,
  localparam int CNT_W = $clog2(FAULTS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             netInit,
  input logic             vecValid,
  input logic [VEC_W-1:0] testVec,
  input logic             scanValid,
  input logic             done,
  input logic             busy,
  input logic [CNT_W-1:0] detCount
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!netInit && !vecValid && !scanValid && !done));
  assert_init_before_apply_R4: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(netInit, 2));
  assert_apply_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);
  assert_count_monotone_R5: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (detCount >= $past(detCount)));
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    detCount <= CNT_W'(FAULTS));
  assert_vector_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> $stable(testVec));
  assert_scan_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    scanValid |-> (busy && !vecValid && !netInit));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
endmodule

bind rand_cov_ctrl rand_cov_ctrl_chk #(.VEC_W(VEC_W), .FAULTS(FAULTS)) chk (
  .clk(clk), .rstN(rstN), .start(start), .netInit(netInit), .vecValid(vecValid),
  .testVec(testVec), .scanValid(scanValid), .done(done), .busy(busy), .detCount(detCount)
);

// File: tb/rand_cov_ctrl_test.sv
`timescale 1ns/1ps
module rand_cov_ctrl_test;
  localparam int VEC_W = 16, FAULTS = 64, CAP_DEPTH = 4, VCNT_W = 16;
  localparam int CNT_W = $clog2(FAULTS + 1), IDX_W = $clog2(FAULTS);

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, simDone = 1'b0, capPop = 1'b0;
  logic [VEC_W-1:0] poly = '0, seed = '0;
  logic [CNT_W-1:0] faultTotal = '0;
  logic [6:0] targetPct = '0;
  logic [VCNT_W-1:0] maxVectors = '0;
  logic [FAULTS-1:0] detectMask = '0;
  logic netInit, vecValid, busy, capValid, scanValid, done;
  logic [VEC_W-1:0] testVec, capVec;
  logic [IDX_W-1:0] scanIdx;
  logic [CNT_W-1:0] detCount;

  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  rand_cov_ctrl #(.VEC_W(VEC_W), .FAULTS(FAULTS), .CAP_DEPTH(CAP_DEPTH), .VCNT_W(VCNT_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .poly(poly), .seed(seed), .faultTotal(faultTotal),
    .targetPct(targetPct), .maxVectors(maxVectors), .simDone(simDone), .detectMask(detectMask),
    .capPop(capPop), .netInit(netInit), .vecValid(vecValid), .testVec(testVec), .busy(busy),
    .capValid(capValid), .capVec(capVec), .scanValid(scanValid), .scanIdx(scanIdx),
    .done(done), .detCount(detCount)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] maskFor(int k, int mode);
    logic [63:0] m;
    case (mode)
      0: begin
        m = (64'h1 << ((k * 7) % 20)) | (64'h1 << (20 + k % 40));
        if (k % 4 == 1) m = m | (64'h1 << ((k * 7 + 7) % 20));
      end
      1: m = 64'h3 << ((k * 5) % 62);
      3: m = 64'h1 << (k % 10);
      default: m = '0;
    endcase
    return m;
  endfunction

  // Runs one campaign against a behavioural model
  task automatic runCase(input logic [15:0] p, input logic [15:0] s, input int tot,
                         input int tgt, input int maxv, input int mode, input bit popEn,
                         input bit glitch);
    logic [15:0] expVec;
    logic [63:0] pend, m, fresh;
    logic [15:0] nxt;
    int det, vecN, initSeen, respondIn, cycles, n;
    bit wrapped, cont, finished, startHeld;
    logic [15:0] capQ[$];
    int scanQ[$];

    expVec = s; det = 0; vecN = 0; initSeen = 0; respondIn = 0; cycles = 0;
    wrapped = 0; finished = 0; startHeld = 0;
    pend = '0;
    for (int i = 0; i < tot; i++) pend[i] = 1'b1;

    @(negedge clk);
    poly = p; seed = s; faultTotal = CNT_W'(tot); targetPct = 7'(tgt);
    maxVectors = VCNT_W'(maxv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!finished && cycles < 30000) begin
      cycles++;
      if (startHeld) begin start = 1'b0; startHeld = 0; end
      if (simDone) simDone = 1'b0;
      if (popEn) begin
        if (capPop) capPop = 1'b0;
        else if (capValid) begin
          if (capQ.size() == 0) chk(0, "R8 unexpected capture", capVec, -1);
          else begin
            chk(capVec == capQ[0], "R8 capture vector", capVec, capQ[0]);
            void'(capQ.pop_front());
          end
          capPop = 1'b1;
        end
      end
      if (respondIn > 0) begin
        respondIn--;
        if (respondIn == 0) begin
          m = maskFor(vecN, mode);
          fresh = m & pend;
          n = $countones(fresh);
          pend = pend & ~m;
          det += n;
          if (n > 0 && (popEn || capQ.size() < CAP_DEPTH)) capQ.push_back(expVec);
          vecN++;
          nxt = {expVec[14:0], ^(expVec & p)};
          wrapped = (nxt == s);
          expVec = nxt;
          detectMask = m;
          simDone = 1'b1;
        end
      end
      if (netInit) initSeen++;
      if (vecValid) begin
        cont = !(det * 100 >= tgt * tot) && !(wrapped || vecN >= maxv);
        chk(cont, "R6/R7 vector applied after stop condition", vecN, -1);
        chk(testVec == expVec, "R3 test vector", testVec, expVec);
        chk(initSeen == 1, "R4 one netInit before apply", initSeen, 1);
        chk(detCount == CNT_W'(det), "R5 detected count", detCount, det);
        chk(busy, "R4 busy during run", busy, 1);
        initSeen = 0;
        respondIn = 1 + (vecN % 3);
        if (glitch && vecN == 2) begin start = 1'b1; startHeld = 1; end // R2 ignored while busy
      end
      if (scanValid) begin
        if (scanQ.size() == 0)
          for (int i = 0; i < FAULTS; i++) if (pend[i]) scanQ.push_back(i);
        if (scanQ.size() == 0) chk(0, "R9 extra undetected index", scanIdx, -1);
        else begin
          chk(int'(scanIdx) == scanQ[0], "R9 undetected index", scanIdx, scanQ[0]);
          void'(scanQ.pop_front());
          pend[scanIdx] = 1'b0;
        end
      end
      if (done) begin
        finished = 1;
        cont = !(det * 100 >= tgt * tot) && !(wrapped || vecN >= maxv);
        chk(!cont, "R6/R7 run ended early", vecN, -1);
        chk(detCount == CNT_W'(det), "R5 final detected count", detCount, det);
        chk(pend == '0, "R9 undetected faults not all reported", $countones(pend), 0);
      end
      if (!finished) @(negedge clk);
    end
    chk(finished, "R9 done pulse seen", finished, 1);
    @(negedge clk);
    simDone = 1'b0;
    chk(!busy && !done, "R9 back to idle", busy, 0);
    // Drain what remains in the capture queue
    capPop = 1'b0;
    for (int k = 0; k < 2 * CAP_DEPTH + 2; k++) begin
      if (capValid) begin
        if (capQ.size() == 0) chk(0, "R8 capture surplus", capVec, -1);
        else begin
          chk(capVec == capQ[0], "R8 drained capture vector", capVec, capQ[0]);
          void'(capQ.pop_front());
        end
        capPop = 1'b1;
      end
      @(negedge clk);
      capPop = 1'b0;
      @(negedge clk);
    end
    chk(capQ.size() == 0, "R8 captures missing", capQ.size(), 0);
  endtask

  initial begin
    #(8 * 190000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !netInit && !vecValid && !scanValid && !capValid && !done, "R1 idle after reset", busy, 0);
    chk(detCount == '0, "R1 count after reset", detCount, 0);
    runCase(16'hB400, 16'hACE1, 20, 100, 1000, 0, 1'b1, 1'b1); // R6 full target, R5 out-of-range mask bits, R2 start while busy
    runCase(16'hB400, 16'h1234, 64, 50, 1000, 1, 1'b1, 1'b0);  // R6 partial target
    runCase(16'hB400, 16'h0F0F, 40, 90, 5, 1, 1'b1, 1'b0);     // R7 vector budget
    runCase(16'h8000, 16'h0001, 16, 100, 1000, 2, 1'b1, 1'b0); // R7 return to seed, R9 full report
    runCase(16'hB400, 16'h5555, 0, 80, 1000, 1, 1'b1, 1'b0);   // R6 empty fault list
    runCase(16'hB400, 16'hBEEF, 30, 100, 12, 3, 1'b0, 1'b0);   // R8 full queue drops pushes
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule